// File: doc/BRIEF.md
# FIFO Event Interrupt Register Bank

This block collects four event conditions from a FIFO-based peripheral and turns them into one level-sensitive interrupt request. Each condition is conditioned (rising-edge capture by default, or level capture per source via a parameter) and latched into a pending-status register. A per-source mask register selects which pending bits may raise the request, and a single master enable bit gates the final output.

Software reaches the three registers over a simple word-wide register bus with separate write and read strobes. Pending bits use toggle-on-write semantics: a 1 written to a pending bit inverts it, a 0 leaves it alone. This lets a handler acknowledge an event by writing back the value it read, and lets test software raise a pending bit on purpose. When hardware raises a bit in the same cycle that software toggles it, the raise wins, so no event is lost.

Top module: `fifo_irq_regs`

## Requirements
- R1: After reset the master enable, pending and mask registers all read zero and `irq_out` is low.
- R2: Byte address 0x1C selects the master-enable register, 0x20 the pending register and 0x28 the mask register; `bus_rdata` is combinational from `bus_addr` while `bus_rd` is high, and is zero for any other address or while `bus_rd` is low.
- R3: Source bits map to the same register bit positions: `src_event[3]` read FIFO full, `[2]` write FIFO empty, `[1]` read FIFO half full, `[0]` write FIFO half full; in edge mode a 0-to-1 transition of a source sets its pending bit at the next clock edge.
- R4: In edge mode a source held high sets its pending bit only once; after software clears it the bit stays clear while the source remains high.
- R5: A write to the pending register inverts every pending bit whose write-data bit is 1 and leaves bits written 0 unchanged, so a 1 both clears a set bit and sets a clear one.
- R6: If a hardware set and a software toggle reach the same pending bit in the same cycle, the bit ends up set.
- R7: A write to the mask register loads bits 3:0 from the write data: 1 enables that source, 0 disables it.
- R8: The master enable is bit 31 of register 0x1C; a write loads it from write-data bit 31.
- R9: Unimplemented bits (31:4 of pending and mask, 30:0 of master enable) read as zero and ignore writes.
- R10: `irq_out` is high exactly when the master enable is set and the AND of pending and mask bits is non-zero.
- R11: A write to an unmapped address changes none of the three registers.
- R12: A source configured for level mode (parameter `LEVEL_MASK` bit 1) sets its pending bit on every cycle it is high, so a software clear does not take while the source stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading a mapped register |
| src_event | input | 4 | Event conditions from the FIFOs |
| irq_out | output | 1 | Level-sensitive interrupt request |

## Verification
Each source is pulsed on its own so that a wrong bit position shows as a wrong pending value, and a source is held high across a software clear to separate edge capture from level capture, with a level-mode instance seeing the same stimulus. A toggle write with mixed ones and zeros, and a toggle of a clear bit, distinguish invert semantics from write-one-to-clear. A source edge coinciding with a toggle of the same set bit exposes the set-versus-toggle priority, and walking the mask and master enable with a pending bit present shows each gate of the interrupt output independently.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_AW   = 8;
    localparam int REG_DW   = 32;
    localparam int GIE_BIT  = 31;

    localparam logic [REG_AW-1:0] OFS_MASTER  = 8'h1C;
    localparam logic [REG_AW-1:0] OFS_PENDING = 8'h20;
    localparam logic [REG_AW-1:0] OFS_MASK    = 8'h28;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASTER,
        SEL_PENDING,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic master;
        logic pending;
        logic mask;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [REG_AW-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_MASTER:  s = SEL_MASTER;
            OFS_PENDING: s = SEL_PENDING;
            OFS_MASK:    s = SEL_MASK;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_pkg::*;
(
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    output reg_sel_e          sel,
    output wr_strobe_t        wstb
);
    always_comb begin
        sel          = decode_addr(addr);
        wstb         = '0;
        wstb.master  = wr && (sel == SEL_MASTER);
        wstb.pending = wr && (sel == SEL_PENDING);
        wstb.mask    = wr && (sel == SEL_MASK);
    end

    always_comb begin
        assert ($countones({wstb.master, wstb.pending, wstb.mask}) <= 1)
            else $error("p_single_strobe_r2");
    end
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond #(
    parameter int                   NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0]   LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src,
    output logic [NUM_SRC-1:0] set_o
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (LEVEL_MASK[i]) begin : g_level
            assign set_o[i] = src[i];
        end else begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= src[i];
            end
            assign set_o[i] = src[i] & ~prev_q;

            // R4: an edge-mode source yields a one-cycle set pulse only
            p_edge_single_r4: assert property (@(posedge clk) disable iff (rst)
                set_o[i] |=> !set_o[i]);
        end
    end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] hw_set,
    input  logic               tog_we,
    input  logic [NUM_SRC-1:0] tog_bits,
    output logic [NUM_SRC-1:0] pend_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                       pend_q[i] <= 1'b0;
            else if (hw_set[i])            pend_q[i] <= 1'b1;
            else if (tog_we && tog_bits[i]) pend_q[i] <= ~pend_q[i];
        end
    end

    // R6: hardware set always lands, whatever software does that cycle
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (|hw_set) |=> ((pend_q & $past(hw_set)) == $past(hw_set)));

    // R5: with no write and no set, pending state holds
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tog_we && hw_set == '0) |=> $stable(pend_q));
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_strobe_t         wstb,
    input  logic [REG_DW-1:0]  wdata,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               master_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            master_q <= 1'b0;
        end else begin
            if (wstb.mask)   mask_q   <= wdata[NUM_SRC-1:0];
            if (wstb.master) master_q <= wdata[GIE_BIT];
        end
    end

    // R7: a mask write lands the low data bits
    p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
        wstb.mask |=> (mask_q == $past(wdata[NUM_SRC-1:0])));

    // R11: without a strobe the control bits hold
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!wstb.mask && !wstb.master) |=> ($stable(mask_q) && $stable(master_q)));
endmodule

// File: rtl/fifo_irq_regs.sv
module fifo_irq_regs
    import irq_pkg::*;
#(
    parameter int                 NUM_SRC    = 4,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [REG_DW-1:0]  bus_wdata,
    output logic [REG_DW-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_event,
    output logic               irq_out
);
    reg_sel_e           sel;
    wr_strobe_t         wstb;
    logic [NUM_SRC-1:0] hw_set;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               master_q;

    irq_bus_decode u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .sel  (sel),
        .wstb (wstb)
    );

    irq_src_cond #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .src   (src_event),
        .set_o (hw_set)
    );

    irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hw_set),
        .tog_we   (wstb.pending),
        .tog_bits (bus_wdata[NUM_SRC-1:0]),
        .pend_q   (pend_q)
    );

    irq_ctrl_regs #(.NUM_SRC(NUM_SRC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wstb     (wstb),
        .wdata    (bus_wdata),
        .mask_q   (mask_q),
        .master_q (master_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_MASTER:  bus_rdata[GIE_BIT]       = master_q;
                SEL_PENDING: bus_rdata[NUM_SRC-1:0]   = pend_q;
                SEL_MASK:    bus_rdata[NUM_SRC-1:0]   = mask_q;
                default:     bus_rdata                = '0;
            endcase
        end
    end

    assign irq_out = master_q & (|(pend_q & mask_q));

    // R10: master enable off keeps the request low
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !master_q |-> !irq_out);

    // R9: unimplemented read bits stay zero
    p_rdata_gap_r9: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[GIE_BIT-1:NUM_SRC] == '0);

    // R2: no read strobe, no read data
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_fifo_irq_regs.sv
`timescale 1ns/1ps
module sim_fifo_irq_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [3:0]  src = '0;
    logic        irq0, irq1;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_MST = 8'h1C;
    localparam logic [7:0] A_PND = 8'h20;
    localparam logic [7:0] A_MSK = 8'h28;

    always #2.5 clk = ~clk;

    fifo_irq_regs u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .src_event(src), .irq_out(irq0)
    );

    fifo_irq_regs #(.LEVEL_MASK(4'b1111)) u1 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .src_event(src), .irq_out(irq1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        d0 = rdata0; d1 = rdata1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int i);
        @(negedge clk); src[i] = 1'b1;
        @(negedge clk); src[i] = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_pending();
        logic [31:0] a, b;
        rd(A_PND, a, b);
        wr(A_PND, a);
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        rd(A_MST, a, b); check("R1 master", a, 32'h0);
        rd(A_PND, a, b); check("R1 pending", a, 32'h0);
        rd(A_MSK, a, b); check("R1 mask", a, 32'h0);
        check("R1 irq", {31'b0, irq0}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] a, b;
        wr(A_MSK, 32'hFFFF_FFF5);
        rd(A_MSK, a, b); check("R7 R9 mask load", a, 32'h5);
        wr(A_MSK, 32'h0000_000A);
        rd(A_MSK, a, b); check("R7 mask reload", a, 32'hA);
        wr(A_MST, 32'hFFFF_FFFF);
        rd(A_MST, a, b); check("R8 R9 master", a, 32'h8000_0000);
        wr(A_MST, 32'h7FFF_FFFF);
        rd(A_MST, a, b); check("R8 master clear", a, 32'h0);
        rd(8'h24, a, b); check("R2 unmapped read", a, 32'h0);
        bus_addr = A_MSK; #0.5;
        check("R2 no strobe", rdata0, 32'h0);
        wr(A_MSK, 32'h0);
    endtask

    task automatic t_positions();
        logic [31:0] a, b;
        for (int i = 0; i < 4; i++) begin
            pulse(i);
            rd(A_PND, a, b); check("R3 bit position", a, 32'h1 << i);
            wr(A_PND, 32'h1 << i);
            rd(A_PND, a, b); check("R5 toggle clear", a, 32'h0);
        end
    endtask

    task automatic t_toggle();
        logic [31:0] a, b;
        pulse(3); pulse(1);
        wr(A_PND, 32'hFFFF_FFF0);
        rd(A_PND, a, b); check("R5 R9 zero write keeps", a, 32'hA);
        wr(A_PND, 32'h0000_000C);
        rd(A_PND, a, b); check("R5 mixed toggle", a, 32'h6);
        clear_pending();
        rd(A_PND, a, b); check("R5 clear back", a, 32'h0);
    endtask

    task automatic t_held();
        logic [31:0] a, b;
        @(negedge clk); src[1] = 1'b1;
        @(negedge clk); @(negedge clk);
        rd(A_PND, a, b); check("R4 held sets", a, 32'h2);
        wr(A_PND, 32'h2);
        @(negedge clk); @(negedge clk); @(negedge clk);
        rd(A_PND, a, b);
        check("R4 held stays clear", a, 32'h0);
        check("R12 level resets bit", b & 32'h2, 32'h2);
        @(negedge clk); src[1] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_collide();
        logic [31:0] a, b;
        pulse(0);
        rd(A_PND, a, b); check("R6 pre", a & 32'h1, 32'h1);
        @(negedge clk);
        src[0] = 1'b1; bus_wr = 1'b1; bus_addr = A_PND; bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; src[0] = 1'b0;
        rd(A_PND, a, b); check("R6 set wins", a & 32'h1, 32'h1);
        clear_pending();
    endtask

    task automatic t_irq();
        logic [31:0] a, b;
        pulse(2);
        check("R10 no mask", {31'b0, irq0}, 32'h0);
        wr(A_MSK, 32'h4);
        check("R10 no master", {31'b0, irq0}, 32'h0);
        wr(A_MST, 32'h8000_0000);
        check("R10 asserted", {31'b0, irq0}, 32'h1);
        wr(A_MSK, 32'hB);
        check("R10 other mask", {31'b0, irq0}, 32'h0);
        wr(A_MSK, 32'h4);
        wr(A_PND, 32'h4);
        check("R10 ack drops", {31'b0, irq0}, 32'h0);
        rd(A_PND, a, b); check("R10 pending gone", a, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] a, b;
        pulse(3);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h21, 32'hFFFF_FFFF);
        rd(A_PND, a, b); check("R11 pending", a, 32'h8);
        rd(A_MSK, a, b); check("R11 mask", a, 32'h4);
        rd(A_MST, a, b); check("R11 master", a, 32'h8000_0000);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_positions();
        t_toggle();
        t_held();
        t_collide();
        t_irq();
        t_unmapped();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule